// File: doc/BRIEF.md
# Memory Bus Lane Substitution Multiplexer

This block sits between the error-correcting core of a memory controller and the wide external data and checkbit pin bus. When one slice of the pin bus has failed for good, a spare slice at the top of the checkbit field can take over that slice's role. On the write side, the chosen slice is copied onto the spare pins and is also still driven at its usual position. On the read side, the value captured from the spare pins replaces the chosen slice before the word goes to the decoder.

The map is selected by a three-bit slice selector and a bus-width mode bit. Both are held in a configuration register that loads only while no memory access is in progress, so every access uses one consistent map. With the default quarter width of 16 the pin bus is 96 bits wide. In the wide mode the data field has four 16-bit quarters, followed by a 16-bit checkbit half and a 16-bit spare. In the narrow mode the data field has four 8-bit quarters, followed by an 8-bit checkbit half and an 8-bit spare.

Top module: `lsub_mux`

## Requirements
- R1: When the registered selector is 0, the pin word driven out equals the logical write word, and the read word equals the pin word captured at the previous clock edge (wide mode).
- R2: Selector values 6 and 7 behave exactly like 0 in both modes.
- R3: In wide mode with selector s from 1 to 5, the spare pins 95:80 carry the write word's slice (bits 15:0, 31:16, 47:32, 63:48 or 79:64 for s = 1..5). Bits 79:0 of the pin word equal the write word in the same cycle, with no register in between.
- R4: In wide mode with selector s from 1 to 5, the read word equals the captured pin word, except that the same slice as in R3 is replaced by captured bits 95:80.
- R5: In narrow mode with selector s from 1 to 5, spare pins 79:72 carry the write word's slice (bits 7:0, 15:8, 23:16, 31:24 or 71:64 for s = 1..5). All other bits below 80 equal the write word.
- R6: In narrow mode with selector s from 1 to 5, the read word equals the captured pin word, except that the slice from R5 is replaced by captured bits 79:72.
- R7: In narrow mode, pin bits 95:80 are driven to 0 and read-word bits 95:80 are 0, whatever the write word and the incoming pins hold.
- R8: The configuration register loads the mode bit and the selector at a clock edge only when the busy input is low. While busy is high, changes on the configuration inputs have no effect on either path.
- R9: Incoming pins are captured at every clock edge into a register that synchronous reset clears. After reset the read word is 0, the mode is wide and the selector is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy | input | 1 | High while a memory access is in progress; blocks configuration loads |
| cfg_narrow | input | 1 | Bus-width mode: 0 wide, 1 narrow |
| cfg_sel | input | 3 | Slice selector: 0 none, 1-4 data quarter, 5 checkbit half, 6-7 none |
| wr_word | input | 96 | Logical write word from the encoder |
| wr_pins | output | 96 | Physical pin word toward memory |
| rd_pins | input | 96 | Physical pin word from memory |
| rd_word | output | 96 | Logical read word toward the decoder |

## Verification
On every cycle, the assertions check that the configuration register holds while busy is high and loads the inputs when busy is low. They also check that the data and checkbit fields of the write path are never modified, that in narrow mode the top slice is zero on both paths, and that the wide-mode spare slice of the read word follows the captured pins. Only the bench scenarios show that each selector value moves the correct slice in each mode, that values 6 and 7 fall back to pass-through, and that configuration changes made during an access stay out of the datapath until busy drops.

// File: rtl/lsub_pkg.sv
package lsub_pkg;

    localparam logic [2:0] SEL_NONE = 3'd0;
    localparam logic [2:0] SEL_CHK  = 3'd5;

    typedef struct packed {
        logic       narrow;
        logic [2:0] sel;
    } lsub_cfg_t;

    typedef struct packed {
        logic        active;
        logic [15:0] base;
        logic [15:0] width;
        logic [15:0] spare;
    } lsub_map_t;

    // Slice geometry for a given configuration and quarter width.
    function automatic lsub_map_t lsub_map(lsub_cfg_t c, int unsigned qw);
        lsub_map_t   m;
        int unsigned w;
        w        = c.narrow ? qw / 2 : qw;
        m.active = (c.sel >= 3'd1) && (c.sel <= SEL_CHK);
        m.width  = 16'(w);
        m.spare  = c.narrow ? 16'(4 * qw + w) : 16'(5 * qw);
        if (c.sel == SEL_CHK)
            m.base = 16'(4 * qw);
        else if (m.active)
            m.base = 16'((int'(c.sel) - 1) * int'(w));
        else
            m.base = 16'd0;
        return m;
    endfunction

endpackage

// File: rtl/lsub_cfg_reg.sv
module lsub_cfg_reg
    import lsub_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      busy,
    input  lsub_cfg_t cfg_in,
    output lsub_cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (!busy)
            cfg_q <= cfg_in;
    end
endmodule

// File: rtl/lsub_wr_path.sv
module lsub_wr_path
    import lsub_pkg::*;
#(
    parameter int unsigned QW = 16
) (
    input  lsub_cfg_t         cfg,
    input  logic [6*QW-1:0]   wr_word,
    output logic [6*QW-1:0]   wr_pins
);
    localparam int unsigned BW = 6 * QW;
    lsub_map_t m;

    always_comb begin
        m       = lsub_map(cfg, QW);
        wr_pins = wr_word;
        if (cfg.narrow)
            wr_pins[5*QW +: QW] = '0;
        if (m.active) begin
            for (int i = 0; i < int'(QW); i++) begin
                if (i < int'(m.width) && (int'(m.spare) + i) < int'(BW))
                    wr_pins[int'(m.spare) + i] = wr_word[int'(m.base) + i];
            end
        end
    end
endmodule

// File: rtl/lsub_rd_path.sv
module lsub_rd_path
    import lsub_pkg::*;
#(
    parameter int unsigned QW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  lsub_cfg_t         cfg,
    input  logic [6*QW-1:0]   rd_pins,
    output logic [6*QW-1:0]   rd_word
);
    localparam int unsigned BW = 6 * QW;
    logic [BW-1:0] pins_q;
    lsub_map_t     m;

    always_ff @(posedge clk) begin
        if (rst)
            pins_q <= '0;
        else
            pins_q <= rd_pins;
    end

    always_comb begin
        m       = lsub_map(cfg, QW);
        rd_word = pins_q;
        if (cfg.narrow)
            rd_word[5*QW +: QW] = '0;
        if (m.active) begin
            for (int i = 0; i < int'(QW); i++) begin
                if (i < int'(m.width) && (int'(m.spare) + i) < int'(BW))
                    rd_word[int'(m.base) + i] = pins_q[int'(m.spare) + i];
            end
        end
    end
endmodule

// File: rtl/lsub_mux.sv
module lsub_mux
    import lsub_pkg::*;
#(
    parameter int unsigned QW = 16,
    localparam int unsigned BW = 6 * QW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          busy,
    input  logic          cfg_narrow,
    input  logic [2:0]    cfg_sel,
    input  logic [BW-1:0] wr_word,
    output logic [BW-1:0] wr_pins,
    input  logic [BW-1:0] rd_pins,
    output logic [BW-1:0] rd_word
);
    lsub_cfg_t cfg_in;
    lsub_cfg_t cfg_q;

    assign cfg_in.narrow = cfg_narrow;
    assign cfg_in.sel    = cfg_sel;

    lsub_cfg_reg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .busy   (busy),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    lsub_wr_path #(.QW(QW)) u_wr (
        .cfg     (cfg_q),
        .wr_word (wr_word),
        .wr_pins (wr_pins)
    );

    lsub_rd_path #(.QW(QW)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg_q),
        .rd_pins (rd_pins),
        .rd_word (rd_word)
    );
endmodule

// File: rtl/lsub_chk.sv
module lsub_chk
    import lsub_pkg::*;
#(
    parameter int unsigned QW = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            busy,
    input logic            cfg_narrow,
    input logic [2:0]      cfg_sel,
    input lsub_cfg_t       cfg_q,
    input logic [6*QW-1:0] wr_word,
    input logic [6*QW-1:0] wr_pins,
    input logic [6*QW-1:0] rd_pins,
    input logic [6*QW-1:0] rd_word
);
    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg_q));

    p_cfg_load_r8: assert property (@(posedge clk) disable iff (rst)
        !busy |=> (cfg_q == $past({cfg_narrow, cfg_sel})));

    p_pass_wr_r1: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.sel == 3'd0 && !cfg_q.narrow) |-> (wr_pins == wr_word));

    p_wide_body_r3: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.narrow |-> (wr_pins[5*QW-1:0] == wr_word[5*QW-1:0]));

    p_narrow_zero_r7: assert property (@(posedge clk) disable iff (rst)
        cfg_q.narrow |-> (wr_pins[5*QW +: QW] == '0 && rd_word[5*QW +: QW] == '0));

    p_spare_follow_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !cfg_q.narrow) |=> (rd_word[5*QW +: QW] == $past(rd_pins[5*QW +: QW])));
endmodule

bind lsub_mux lsub_chk #(.QW(QW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .cfg_narrow (cfg_narrow),
    .cfg_sel    (cfg_sel),
    .cfg_q      (cfg_q),
    .wr_word    (wr_word),
    .wr_pins    (wr_pins),
    .rd_pins    (rd_pins),
    .rd_word    (rd_word)
);

// File: tb/lsub_mux_tb.sv
module lsub_mux_tb;
    localparam int BW = 96;

    logic          clk = 1'b0;
    logic          rst;
    logic          busy;
    logic          cfg_narrow;
    logic [2:0]    cfg_sel;
    logic [BW-1:0] wr_word;
    logic [BW-1:0] wr_pins;
    logic [BW-1:0] rd_pins;
    logic [BW-1:0] rd_word;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    lsub_mux u_dut (
        .clk        (clk),
        .rst        (rst),
        .busy       (busy),
        .cfg_narrow (cfg_narrow),
        .cfg_sel    (cfg_sel),
        .wr_word    (wr_word),
        .wr_pins    (wr_pins),
        .rd_pins    (rd_pins),
        .rd_word    (rd_word)
    );

    function automatic logic [BW-1:0] pat(int k);
        logic [BW-1:0] v;
        for (int j = 0; j < 3; j++)
            v[32*j +: 32] = 32'h9E3779B9 * 32'(k * 3 + j + 1);
        return v;
    endfunction

    // Expected pin word for a write, from the slice tables.
    function automatic logic [BW-1:0] exp_wr(logic n, logic [2:0] s, logic [BW-1:0] w);
        logic [BW-1:0] e;
        e = w;
        if (!n) begin
            if (s >= 1 && s <= 5) e[95:80] = w[16*(int'(s)-1) +: 16];
        end else begin
            e[95:80] = '0;
            if (s >= 1 && s <= 4) e[79:72] = w[8*(int'(s)-1) +: 8];
            else if (s == 5)      e[79:72] = w[71:64];
        end
        return e;
    endfunction

    function automatic logic [BW-1:0] exp_rd(logic n, logic [2:0] s, logic [BW-1:0] p);
        logic [BW-1:0] e;
        e = p;
        if (!n) begin
            if (s >= 1 && s <= 5) e[16*(int'(s)-1) +: 16] = p[95:80];
        end else begin
            e[95:80] = '0;
            if (s >= 1 && s <= 4) e[8*(int'(s)-1) +: 8] = p[79:72];
            else if (s == 5)      e[71:64] = p[79:72];
        end
        return e;
    endfunction

    task automatic check(string req, logic [BW-1:0] act, logic [BW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic string tag_wr(logic n, logic [2:0] s);
        if (s == 0)      return "R1";
        if (s > 5)       return "R2";
        return n ? "R5" : "R3";
    endfunction

    function automatic string tag_rd(logic n, logic [2:0] s);
        if (s == 0)      return "R1";
        if (s > 5)       return "R2";
        return n ? "R6" : "R4";
    endfunction

    task automatic load_cfg(logic n, logic [2:0] s);
        @(negedge clk);
        busy = 1'b0; cfg_narrow = n; cfg_sel = s;
        @(negedge clk);
        busy = 1'b1;
    endtask

    // Drive one access at a negedge; check write now and read a cycle later.
    task automatic access(logic n, logic [2:0] s, int k);
        wr_word = pat(k);
        rd_pins = pat(k + 50);
        #1;
        check(tag_wr(n, s), wr_pins, exp_wr(n, s, wr_word));
        if (n) check("R7", wr_pins[95:80], '0);
        @(negedge clk);
        check(tag_rd(n, s), rd_word, exp_rd(n, s, pat(k + 50)));
        if (n) check("R7", rd_word[95:80], '0);
    endtask

    initial begin
        rst = 1'b1; busy = 1'b0; cfg_narrow = 1'b0; cfg_sel = 3'd0;
        wr_word = '0; rd_pins = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        busy = 1'b1;
        cfg_narrow = 1'b1; cfg_sel = 3'd3;
        wr_word = pat(7);
        #1;
        // R9: reset state, read capture cleared and pass-through map.
        check("R9", rd_word, '0);
        check("R9", wr_pins, pat(7));
        @(negedge clk);
        check("R9", rd_word, '1);

        // Sweep both modes and all selector values.
        for (int n = 0; n < 2; n++) begin
            for (int s = 0; s < 8; s++) begin
                load_cfg(n[0], s[2:0]);
                for (int k = 0; k < 3; k++)
                    access(n[0], s[2:0], s * 10 + k + n * 100);
            end
        end

        // R8: configuration changes during busy have no effect.
        load_cfg(1'b0, 3'd2);
        cfg_narrow = 1'b1; cfg_sel = 3'd4;
        @(negedge clk);
        access(1'b0, 3'd2, 300);
        check("R8", wr_pins[95:80], pat(300)[31:16]);
        busy = 1'b0;
        @(negedge clk);
        busy = 1'b1;
        access(1'b1, 3'd4, 301);
        check("R8", wr_pins[79:72], pat(301)[31:24]);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule